// File: doc/BRIEF.md
# I2C Master Transmit Byte Queue with No-Acknowledge Abort

This block sits between a register write port and the byte shifter of an I2C master. Software loads outgoing bytes through a data write strobe. The queue hands them one at a time to the bit engine over a request/done handshake. The engine reports, for each byte, whether the slave acknowledged it. The queue holds up to `DEPTH` bytes (64 by default).

When the slave answers with a no-acknowledge, draining stops at once. The bytes still queued stay in place, and a sticky no-ACK flag is raised. Software must then issue a flush through the control word before traffic can resume. A flush may re-enable queue mode in the same write.

Two views of emptiness are provided:
- an interrupt status bit that is set only when the final byte has been acknowledged;
- a live status word that simply tracks whether the queue holds anything.

A single interrupt line combines the status bits with their enables.

Top module: `i2c_txq_top`

## Requirements
- R1: After a synchronous active-low reset the queue is empty (`fifo_stat` bit 4 = 1), queue mode is off (`ctl_rd` = 0), `int_stat` = 0, `eng_req` = 0 and `irq` = 0.
- R2: While queue mode is on, each `wr_data_en` pulse stores one byte. Bytes reach `eng_byte` in exactly the order they were written.
- R3: A byte written while queue mode is off, or while `DEPTH` bytes are already held, is discarded. Stored bytes are not altered, and the held count never exceeds `DEPTH`.
- R4: `eng_req` is high whenever the queue is non-empty, queue mode is on and no abort is pending. `eng_byte` holds the oldest byte, unchanged, until `eng_done` is pulsed. That pulse removes the byte.
- R5: An `eng_done` with `eng_nak` = 1 removes only the refused byte, stops all further requests, and sets `int_stat` bit 0 and `ctl_rd` bit 3. The remaining bytes stay queued.
- R6: A control write with bit 7 = 1 discards every queued byte and clears the abort (`ctl_rd` bit 3). The same write's bit 6 sets the new queue-mode enable, so writing 0xC0 flushes and re-enables in one step.
- R7: `int_stat` bit 1 is set only when the last queued byte completes with an acknowledge. A byte refused with no-ACK does not set it, and neither does a flush.
- R8: `fifo_stat` bit 4 is a live level that is 1 exactly when the queue holds no byte.
- R9: Writing a 1 to a bit through `wr_iclr` clears that `int_stat` bit. `irq` is high when any `int_stat` bit is set and its enable bit in the `wr_ien` word (bit 0 no-ACK, bit 1 empty) is set.
- R10: `ctl_rd` bit 6 reads back the current queue-mode enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_data_en | input | 1 | Data write strobe (push one byte) |
| wr_data | input | DW | Byte to push |
| wr_ctl_en | input | 1 | Control word write strobe |
| wr_ctl | input | 8 | Control word: bit 7 flush, bit 6 queue enable |
| wr_ien_en | input | 1 | Interrupt-enable word write strobe |
| wr_ien | input | 2 | Interrupt enables: bit 1 empty, bit 0 no-ACK |
| wr_iclr_en | input | 1 | Interrupt status clear strobe |
| wr_iclr | input | 2 | Write-1-to-clear mask for `int_stat` |
| eng_req | output | 1 | Byte available for the bit engine |
| eng_byte | output | DW | Oldest queued byte |
| eng_done | input | 1 | Bit engine finished the offered byte |
| eng_nak | input | 1 | Slave refused the byte (valid with `eng_done`) |
| ctl_rd | output | 8 | Control readback: bit 6 enable, bit 3 no-ACK abort pending |
| int_stat | output | 2 | Sticky status: bit 1 queue drained, bit 0 no-ACK |
| fifo_stat | output | 8 | Live status word: bit 4 queue empty |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with `DEPTH` = 8 and `DW` = 8. With that depth, the full-queue drop and the wrap of both pointers are reached in a few dozen cycles. A no-ACK arriving midway through a batch leaves bytes behind that a later flush must discard. The byte ordering, the drop on overflow and the abort all behave the same at the default depth of 64.

// File: rtl/i2c_txq_pkg.sv
// Package: i2c_txq_pkg
// Bit positions shared by the transmit queue, its checker and software.
// Assumes an 8-bit control and status word layout.
package i2c_txq_pkg;
    localparam int CTL_FLUSH_BIT = 7;
    localparam int CTL_EN_BIT    = 6;
    localparam int CTL_NAK_BIT   = 3;
    localparam int FST_EMPTY_BIT = 4;
    localparam int IST_EMPTY_BIT = 1;
    localparam int IST_NAK_BIT   = 0;
    localparam int IST_W         = 2;
endpackage

// File: rtl/txq_store.sv
// Module: txq_store
// Circular byte store with write/read pointers and an occupancy count.
// Assumes: flush has priority over push and pop; push when full and pop
// when empty are ignored; the head entry is read combinationally.
module txq_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] level,
    output logic          empty,
    output logic          full
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, pop_ok;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (level == '0);
    assign full    = (level == CW'(DEPTH));
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign head    = mem[rd_ptr];

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wrap_inc(wr_ptr);
            if (pop_ok)  rd_ptr <= wrap_inc(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // Entry storage; only accepted pushes write.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end
endmodule

// File: rtl/txq_ctrl.sv
// Module: txq_ctrl
// Queue-mode enable, no-ACK abort, interrupt status/enable and handshake.
// Assumes: eng_done is a one-cycle pulse honoured only while eng_req is
// high; a status set wins over a clear in the same cycle.
module txq_ctrl
    import i2c_txq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_flush,
    input  logic             ctl_en,
    input  logic             ien_wr,
    input  logic [IST_W-1:0] ien_val,
    input  logic             iclr_wr,
    input  logic [IST_W-1:0] iclr_val,
    input  logic             done,
    input  logic             nak,
    input  logic             q_empty,
    input  logic             q_last,
    output logic             en,
    output logic             halt,
    output logic             flush,
    output logic             req,
    output logic             pop,
    output logic [IST_W-1:0] isr,
    output logic [IST_W-1:0] ier
);
    logic             set_nak, set_empty;
    logic [IST_W-1:0] set_vec, clr_vec;

    assign flush     = ctl_wr && ctl_flush;
    assign req       = en && !halt && !q_empty;
    assign pop       = req && done && !flush;
    assign set_nak   = pop && nak;
    assign set_empty = pop && !nak && q_last;

    always_comb begin
        set_vec                = '0;
        set_vec[IST_NAK_BIT]   = set_nak;
        set_vec[IST_EMPTY_BIT] = set_empty;
        clr_vec                = iclr_wr ? iclr_val : '0;
    end

    // Queue-mode enable follows every control write.
    always_ff @(posedge clk) begin
        if (!rst_n)      en <= 1'b0;
        else if (ctl_wr) en <= ctl_en;
    end

    // Abort latch: set by a refused byte, released only by a flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) halt <= 1'b0;
        else if (set_nak)    halt <= 1'b1;
    end

    // Sticky interrupt status with write-1-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) isr <= '0;
        else        isr <= (isr & ~clr_vec) | set_vec;
    end

    // Interrupt enable word.
    always_ff @(posedge clk) begin
        if (!rst_n)      ier <= '0;
        else if (ien_wr) ier <= ien_val;
    end
endmodule

// File: rtl/i2c_txq_top.sv
// Module: i2c_txq_top
// I2C master transmit byte queue with no-ACK abort. Joins the byte store
// and the control logic and forms the readback and status words.
// Assumes: the bit engine pulses eng_done once per offered byte.
module i2c_txq_top
    import i2c_txq_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_data_en,
    input  logic [DW-1:0]    wr_data,
    input  logic             wr_ctl_en,
    input  logic [7:0]       wr_ctl,
    input  logic             wr_ien_en,
    input  logic [IST_W-1:0] wr_ien,
    input  logic             wr_iclr_en,
    input  logic [IST_W-1:0] wr_iclr,
    output logic             eng_req,
    output logic [DW-1:0]    eng_byte,
    input  logic             eng_done,
    input  logic             eng_nak,
    output logic [7:0]       ctl_rd,
    output logic [IST_W-1:0] int_stat,
    output logic [7:0]       fifo_stat,
    output logic             irq
);
    logic          q_en, q_halt, q_flush, q_pop, q_empty, q_full, q_last, push_req;
    logic [CW-1:0] q_level;
    logic [IST_W-1:0] q_ier;
    logic          unused_ctl_bits;

    assign unused_ctl_bits = ^wr_ctl[5:0];
    assign push_req = wr_data_en && q_en;
    // The byte being removed is the final one unless a push lands alongside it.
    assign q_last   = (q_level == CW'(1)) && !(push_req && !q_full);

    txq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (q_flush),
        .push      (push_req),
        .push_data (wr_data),
        .pop       (q_pop),
        .head      (eng_byte),
        .level     (q_level),
        .empty     (q_empty),
        .full      (q_full)
    );

    txq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (wr_ctl_en),
        .ctl_flush (wr_ctl[CTL_FLUSH_BIT]),
        .ctl_en    (wr_ctl[CTL_EN_BIT]),
        .ien_wr    (wr_ien_en),
        .ien_val   (wr_ien),
        .iclr_wr   (wr_iclr_en),
        .iclr_val  (wr_iclr),
        .done      (eng_done),
        .nak       (eng_nak),
        .q_empty   (q_empty),
        .q_last    (q_last),
        .en        (q_en),
        .halt      (q_halt),
        .flush     (q_flush),
        .req       (eng_req),
        .pop       (q_pop),
        .isr       (int_stat),
        .ier       (q_ier)
    );

    // Readback and status word assembly.
    always_comb begin
        ctl_rd                   = '0;
        ctl_rd[CTL_EN_BIT]       = q_en;
        ctl_rd[CTL_NAK_BIT]      = q_halt;
        fifo_stat                = '0;
        fifo_stat[FST_EMPTY_BIT] = q_empty;
        irq                      = |(int_stat & q_ier);
    end
endmodule

// File: rtl/i2c_txq_checker.sv
// Module: i2c_txq_checker
// Temporal checks on the transmit queue, bound to i2c_txq_top.
module i2c_txq_checker #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          eng_req,
    input logic [DW-1:0] eng_byte,
    input logic          eng_done,
    input logic          eng_nak,
    input logic          wr_ctl_en,
    input logic [7:0]    wr_ctl,
    input logic [7:0]    ctl_rd,
    input logic [1:0]    int_stat,
    input logic [7:0]    fifo_stat,
    input logic [CW-1:0] level
);
    logic flushing;
    assign flushing = wr_ctl_en && wr_ctl[7];

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));

    assert_hold_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_done && !wr_ctl_en) |=> (eng_req && $stable(eng_byte)));

    assert_halt_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd[3] |-> !eng_req);

    assert_nak_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_done && eng_nak && !flushing) |=> (int_stat[0] && ctl_rd[3]));

    assert_flush_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flushing |=> (fifo_stat[4] && !ctl_rd[3]));

    assert_empty_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_stat[1]) |-> $past(eng_req && eng_done && !eng_nak));
endmodule

bind i2c_txq_top i2c_txq_checker #(.DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .eng_req   (eng_req),
    .eng_byte  (eng_byte),
    .eng_done  (eng_done),
    .eng_nak   (eng_nak),
    .wr_ctl_en (wr_ctl_en),
    .wr_ctl    (wr_ctl),
    .ctl_rd    (ctl_rd),
    .int_stat  (int_stat),
    .fifo_stat (fifo_stat),
    .level     (q_level)
);

// File: tb/sim_i2c_txq_top.sv
// Scoreboard bench: pushes record expected bytes, a sink model pops and compares.
module sim_i2c_txq_top;
    localparam int DW = 8;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_data_en = 1'b0, wr_ctl_en = 1'b0, wr_ien_en = 1'b0, wr_iclr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [7:0] wr_ctl = '0;
    logic [1:0] wr_ien = '0, wr_iclr = '0;
    logic eng_done = 1'b0, eng_nak = 1'b0;
    logic eng_req, irq;
    logic [DW-1:0] eng_byte;
    logic [7:0] ctl_rd, fifo_stat;
    logic [1:0] int_stat;

    int checks = 0;
    int errors = 0;
    bit sink_on = 1'b0;
    int nak_after = -1;
    logic [DW-1:0] exp_q[$];

    always #2.5 clk = ~clk;

    i2c_txq_top #(.DW(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_data_en(wr_data_en), .wr_data(wr_data),
        .wr_ctl_en(wr_ctl_en), .wr_ctl(wr_ctl),
        .wr_ien_en(wr_ien_en), .wr_ien(wr_ien),
        .wr_iclr_en(wr_iclr_en), .wr_iclr(wr_iclr),
        .eng_req(eng_req), .eng_byte(eng_byte),
        .eng_done(eng_done), .eng_nak(eng_nak),
        .ctl_rd(ctl_rd), .int_stat(int_stat), .fifo_stat(fifo_stat), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic push(input logic [DW-1:0] b, input bit keep);
        wr_data_en = 1'b1; wr_data = b;
        if (keep) exp_q.push_back(b);
        @(negedge clk);
        wr_data_en = 1'b0;
    endtask

    task automatic ctl(input logic [7:0] v);
        wr_ctl_en = 1'b1; wr_ctl = v;
        @(negedge clk);
        wr_ctl_en = 1'b0;
    endtask

    task automatic ien(input logic [1:0] v);
        wr_ien_en = 1'b1; wr_ien = v;
        @(negedge clk);
        wr_ien_en = 1'b0;
    endtask

    task automatic iclr(input logic [1:0] v);
        wr_iclr_en = 1'b1; wr_iclr = v;
        @(negedge clk);
        wr_iclr_en = 1'b0;
    endtask

    // Sink model: serves each offered byte after two cycles and compares it (R2, R3).
    initial begin
        forever begin
            @(negedge clk);
            if (sink_on && eng_req) begin
                repeat (2) @(negedge clk);
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R3: actual byte %0h expected none", eng_byte);
                end else begin
                    check("R2 order", eng_byte, exp_q.pop_front());
                end
                eng_nak = (nak_after == 0);
                if (nak_after >= 0) nak_after--;
                eng_done = 1'b1;
                @(negedge clk);
                eng_done = 1'b0; eng_nak = 1'b0;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 empty", fifo_stat, 8'h10);
        check("R1 ctl", ctl_rd, 0);
        check("R1 int", int_stat, 0);
        check("R1 req/irq", {eng_req, irq}, 0);

        ctl(8'h40);
        check("R10 enable readback", ctl_rd[6], 1);

        // R4: bytes wait for the engine
        push(8'hA1, 1); push(8'hA2, 1); push(8'hA3, 1);
        check("R8 not empty", fifo_stat[4], 0);
        check("R4 req", eng_req, 1);
        check("R4 head", eng_byte, 8'hA1);
        repeat (4) @(negedge clk);
        check("R4 head held", eng_byte, 8'hA1);

        sink_on = 1'b1;
        repeat (30) @(negedge clk);
        check("R2 all served", exp_q.size(), 0);
        check("R7 drained event", int_stat[1], 1);
        check("R8 empty again", fifo_stat[4], 1);

        ien(2'b10);
        check("R9 irq on", irq, 1);
        iclr(2'b10);
        check("R9 cleared", {int_stat, irq}, 0);

        // R3: overflow drop
        sink_on = 1'b0;
        for (int i = 0; i < DEPTH + 3; i++) push(DW'(8'h10 + i), i < DEPTH);
        check("R3 held", fifo_stat[4], 0);
        sink_on = 1'b1;
        repeat (DEPTH * 5 + 20) @(negedge clk);
        check("R3 only DEPTH served", exp_q.size(), 0);
        check("R3 drained", eng_req, 0);

        // R3: push while disabled is dropped
        ctl(8'h00);
        push(8'h55, 0);
        ctl(8'h40);
        repeat (10) @(negedge clk);
        check("R3 disabled push", fifo_stat[4], 1);
        iclr(2'b11);

        // R5: NAK on second byte
        sink_on = 1'b0;
        push(8'hB1, 1); push(8'hB2, 1); push(8'hB3, 1); push(8'hB4, 1);
        nak_after = 1;
        sink_on = 1'b1;
        repeat (30) @(negedge clk);
        check("R5 noack status", int_stat[0], 1);
        check("R5 abort readback", ctl_rd[3], 1);
        check("R5 no request", eng_req, 0);
        check("R5 rest kept", fifo_stat[4], 0);
        check("R7 no event on nak", int_stat[1], 0);
        check("R5 rest unsent", exp_q.size(), 2);

        // R6: flush alone disables, flush with enable re-enables
        ctl(8'h80);
        exp_q.delete();
        check("R6 flushed", fifo_stat[4], 1);
        check("R6 abort cleared", ctl_rd[3], 0);
        check("R6 enable off", ctl_rd[6], 0);
        check("R6 noack sticky", int_stat[0], 1);
        check("R7 no event on flush", int_stat[1], 0);
        ctl(8'hC0);
        check("R6 flush+enable", ctl_rd[6], 1);
        push(8'hC1, 1); push(8'hC2, 1);
        repeat (20) @(negedge clk);
        check("R2 after flush", exp_q.size(), 0);
        check("R7 drained again", int_stat[1], 1);

        // R9 no-ACK interrupt path
        ien(2'b01);
        check("R9 noack irq", irq, 1);
        iclr(2'b01);
        check("R9 noack cleared", {int_stat[0], irq}, 0);

        finish_up();
    end
endmodule